// File: doc/BRIEF.md
# Bus-master write FIFO engine

This block is the outbound path for a bus-master write burst. The add-on side pushes 32-bit words into an 8-entry FIFO. A simplified PCI-style initiator drains that FIFO onto the bus. It drives the frame and initiator-ready strobes (active low) and answers the target-ready and stop strobes that come back. The add-on write handshake is sampled on the bus clock, so a word enters the FIFO at the edge where valid and ready are both high. No address phase, arbitration or parity is modelled. A transaction begins with the first data phase.

A byte counter, loaded by the add-on, limits how much data goes out. It drops by 4 only when a data phase completes. When it reaches zero, a completion flag is set and can be routed to the interrupt output. If the target retries a word, that word leaves the FIFO for a one-word holding register. It is resent ahead of any FIFO data. So the FIFO-empty flag says only that all 8 locations are free. The interrupt is the reliable sign that the last byte was taken.

The engine works out whether the coming data phase is the last one from what it has already stored. A word that the add-on writes while the last phase is in flight never extends the burst. That word waits for a later transaction.

Top module: `bmw_engine`

## Requirements
- R1: After reset, frame_n and irdy_n are 1, fifo_empty is 1, aon_ready is 1 and irq is 0.
- R2: The FIFO holds 8 words. aon_ready is 0 exactly when 8 words are stored, and a write with aon_ready 0 is not taken. fifo_empty is 1 exactly when all 8 locations are free.
- R3: Words reach the bus in the order they were written, with no word lost or repeated. A word counts as sent on a clock edge where irdy_n is 0 and trdy_n is 0. This holds under any mix of retries, waits and disconnects.
- R4: On a retry (irdy_n 0, trdy_n 1, stop_n 0), the word moves from the FIFO into a holding register. The FIFO location is freed, and fifo_empty may go to 1 while that word is still unsent. The held word is the next word presented.
- R5: frame_n is 0 only while irdy_n is 0. The engine sets frame_n to 1 before the last data phase completes. A phase is last when it presents the only stored word or when 4 bytes remain in the count.
- R6: Once frame_n is 1 with irdy_n 0, frame_n stays 1 until irdy_n returns to 1. A word written in that window is sent in a later transaction. When the engine itself ends a transaction, frame_n was already 1 on the cycle before irdy_n rises.
- R7: The byte count drops by 4 only on a data phase that completes. Retried and waiting phases leave it unchanged.
- R8: The completion flag is set when a completed phase takes the count from 4 to 0, and it is cleared by a count load. irq equals the flag ANDed with irq_en, so irq never goes to 1 before the last counted word has been accepted.
- R9: A count load of 4 during a running transaction lets exactly one more data phase complete. The engine then releases the bus, even if the FIFO still holds data.
- R10: A disconnect (irdy_n 0, trdy_n 0, stop_n 0) accepts the word and ends the transaction. A retry ends it without accepting the word. The engine starts a new transaction after at least two idle cycles while a word is stored and the count is non-zero.
- R11: While the count is zero, no transaction starts, whatever the FIFO holds.
- R12: While a phase waits (irdy_n 0, trdy_n 1, stop_n 1), irdy_n stays 0 and ad_out stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aon_valid | input | 1 | Add-on offers a word |
| aon_ready | output | 1 | FIFO has room; word taken when valid and ready |
| aon_data | input | 32 | Add-on write data |
| cnt_load | input | 1 | Load the byte counter this cycle |
| cnt_value | input | 16 | Byte count to load |
| irq_en | input | 1 | Route completion flag to irq |
| irq | output | 1 | Completion interrupt |
| fifo_empty | output | 1 | All FIFO locations free |
| frame_n | output | 1 | Frame strobe, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop, active low |
| ad_out | output | 32 | Data presented on the bus |

## Verification
An add-on push and the end-of-burst decision can land in the same cycle. The bench holds the target in wait states during a last phase that carries a single word, and writes a new word in that window. It then requires frame_n to stay 1 until irdy_n rises, and requires the new word to go out in a second transaction. A retry and the FIFO-empty flag also meet in one cycle. The bench retries a lone word and requires fifo_empty to be 1 with irq still 0. irq may rise only after the resent word is accepted.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_DATA = 2'd1,
    XS_TURN = 2'd2
  } xs_t;
endpackage

// File: rtl/bmw_fifo.sv
module bmw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp <= wrap_inc(wp);
      if (do_pop)  rp <= wrap_inc(rp);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/bmw_count.sv
module bmw_count #(
  parameter int CNT_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nx,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_comb begin
    if (load)                             cnt_nx = load_val;
    else if (dec && cnt_q >= CNT_W'(STEP)) cnt_nx = cnt_q - CNT_W'(STEP);
    else if (dec)                         cnt_nx = '0;
    else                                  cnt_nx = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      if (load)                                    done_q <= 1'b0;
      else if (dec && cnt_q == CNT_W'(STEP))       done_q <= 1'b1;
    end
  end

  assign cnt = cnt_q;
  assign irq = done_q && irq_en;
endmodule

// File: rtl/bmw_xfer.sv
module bmw_xfer
  import bmw_pkg::*;
#(
  parameter int W     = 32,
  parameter int CW    = 4,
  parameter int CNT_W = 16,
  parameter int STEP  = 4,
  localparam int AVW  = CW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trdy_n,
  input  logic             stop_n,
  input  logic [W-1:0]     head,
  input  logic [CW-1:0]    fcount,
  input  logic [CNT_W-1:0] cnt_nx,
  output logic             frame_n,
  output logic             irdy_n,
  output logic [W-1:0]     ad_out,
  output logic             pop,
  output logic             accept
);
  xs_t            st;
  logic [W-1:0]   hold_q;
  logic           hold_v;
  logic [AVW-1:0] avail;
  logic           retry, in_phase, more_cnt;

  assign avail    = AVW'(fcount) + AVW'(hold_v);
  assign in_phase = (st == XS_DATA);
  assign accept   = in_phase && !trdy_n;
  assign retry    = in_phase && trdy_n && !stop_n;
  assign pop      = (accept || retry) && !hold_v;
  assign ad_out   = hold_v ? hold_q : head;
  assign more_cnt = (cnt_nx > CNT_W'(STEP));

  // Holding register: a retried FIFO word parks here and goes out first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
    end else if (retry && !hold_v) begin
      hold_v <= 1'b1;
      hold_q <= head;
    end else if (accept && hold_v) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= XS_IDLE;
      frame_n <= 1'b1;
      irdy_n  <= 1'b1;
    end else begin
      case (st)
        XS_IDLE: begin
          if (avail != '0 && cnt_nx != '0) begin
            st      <= XS_DATA;
            irdy_n  <= 1'b0;
            frame_n <= !(avail >= AVW'(2) && more_cnt);
          end
        end
        XS_DATA: begin
          if (accept && !frame_n && stop_n) begin
            frame_n <= !(avail >= AVW'(3) && more_cnt);
          end else if (accept || retry) begin
            st      <= XS_TURN;
            frame_n <= 1'b1;
            irdy_n  <= 1'b1;
          end else begin
            frame_n <= frame_n | !more_cnt;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bmw_engine.sv
module bmw_engine #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  localparam int STEP  = DATA_W / 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aon_valid,
  output logic              aon_ready,
  input  logic [DATA_W-1:0] aon_data,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_value,
  input  logic              irq_en,
  output logic              irq,
  output logic              fifo_empty,
  output logic              frame_n,
  output logic              irdy_n,
  input  logic              trdy_n,
  input  logic              stop_n,
  output logic [DATA_W-1:0] ad_out
);
  logic [DATA_W-1:0] head;
  logic [CW-1:0]     fcount;
  logic              full, pop, accept;
  logic [CNT_W-1:0]  cnt, cnt_nx;

  assign aon_ready = !full;

  bmw_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(aon_valid), .wdata(aon_data),
    .pop(pop), .rdata(head), .count(fcount), .full(full), .empty(fifo_empty)
  );

  bmw_count #(.CNT_W(CNT_W), .STEP(STEP)) u_count (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_value),
    .dec(accept), .irq_en(irq_en), .cnt(cnt), .cnt_nx(cnt_nx), .irq(irq)
  );

  bmw_xfer #(.W(DATA_W), .CW(CW), .CNT_W(CNT_W), .STEP(STEP)) u_xfer (
    .clk(clk), .rst_n(rst_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .head(head), .fcount(fcount), .cnt_nx(cnt_nx),
    .frame_n(frame_n), .irdy_n(irdy_n), .ad_out(ad_out),
    .pop(pop), .accept(accept)
  );
endmodule

// File: rtl/bmw_engine_chk.sv
module bmw_engine_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              aon_ready,
  input logic              irq,
  input logic              irq_en,
  input logic              fifo_empty,
  input logic              frame_n,
  input logic              irdy_n,
  input logic              trdy_n,
  input logic              stop_n,
  input logic [DATA_W-1:0] ad_out
);
  // R5
  frame_needs_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> !irdy_n);
  // R6
  last_phase_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_n && !irdy_n) |=> frame_n);
  // R6
  master_end_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irdy_n) && $past(stop_n)) |-> $past(frame_n));
  // R2
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aon_ready |-> !fifo_empty);
  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  // R10
  stop_ends_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !stop_n) |=> irdy_n);
  // R12
  wait_keeps_irdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n && stop_n) |=> !irdy_n);
  // R12
  wait_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && trdy_n && stop_n) |=> $stable(ad_out));
endmodule

bind bmw_engine bmw_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .aon_ready(aon_ready), .irq(irq), .irq_en(irq_en),
  .fifo_empty(fifo_empty), .frame_n(frame_n), .irdy_n(irdy_n),
  .trdy_n(trdy_n), .stop_n(stop_n), .ad_out(ad_out)
);

// File: tb/bmw_engine_bench.sv
module bmw_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aon_valid = 1'b0;
  logic        aon_ready;
  logic [31:0] aon_data = '0;
  logic        cnt_load = 1'b0;
  logic [15:0] cnt_value = '0;
  logic        irq_en = 1'b1;
  logic        irq, fifo_empty, frame_n, irdy_n;
  logic        trdy_n = 1'b1;
  logic        stop_n = 1'b1;
  logic [31:0] ad_out;

  bmw_engine u_bmw_engine (
    .clk(clk), .rst_n(rst_n), .aon_valid(aon_valid), .aon_ready(aon_ready),
    .aon_data(aon_data), .cnt_load(cnt_load), .cnt_value(cnt_value),
    .irq_en(irq_en), .irq(irq), .fifo_empty(fifo_empty), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n), .ad_out(ad_out)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  int acc_since = 0, loaded = 0, txn = 0, load_guard = 0;
  int mode = 0, retry_budget = 0;   // 0 accept,1 random,2 wait,3 retry then accept,4 disconnect
  logic prev_frame = 1'b1, prev_irdy = 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Target model plus scoreboard monitor, evaluated away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (load_guard > 0) load_guard--;
      else if (irq) chk(acc_since * 4 >= loaded, "R8 irq before last word", acc_since * 4, loaded);
      if (!frame_n && irdy_n) chk(0, "R5 frame without irdy", {frame_n, irdy_n}, 2'b10);
      if (prev_frame && !prev_irdy && !irdy_n && !frame_n)
        chk(0, "R6 frame reasserted in last phase", frame_n, 1);
      if (!irdy_n && prev_irdy) txn++;
      prev_frame = frame_n;
      prev_irdy  = irdy_n;
    end
    if (!irdy_n) begin
      int r;
      case (mode)
        1: begin
          r = $urandom % 8;
          if (r < 4)       begin trdy_n = 0; stop_n = 1; end
          else if (r == 4) begin trdy_n = 1; stop_n = 0; end
          else if (r == 5) begin trdy_n = 0; stop_n = 0; end
          else             begin trdy_n = 1; stop_n = 1; end
        end
        2: begin trdy_n = 1; stop_n = 1; end
        3: if (retry_budget > 0) begin retry_budget--; trdy_n = 1; stop_n = 0; end
           else begin trdy_n = 0; stop_n = 1; end
        4: begin trdy_n = 0; stop_n = 0; end
        default: begin trdy_n = 0; stop_n = 1; end
      endcase
    end else begin
      trdy_n = 1; stop_n = 1;
    end
    if (!irdy_n && !trdy_n) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected word", ad_out, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(ad_out == e, "R3 word order", ad_out, e);
      end
      acc_since++;
    end
  end

  task automatic push_word(input logic [31:0] d);
    while (!aon_ready) @(negedge clk);
    aon_data  = d;
    aon_valid = 1'b1;
    exp_q.push_back(d);
    @(negedge clk);
    aon_valid = 1'b0;
  endtask

  task automatic load_count(input int v);
    cnt_value  = 16'(v);
    cnt_load   = 1'b1;
    loaded     = v;
    acc_since  = 0;
    load_guard = 2;
    @(negedge clk);
    cnt_load = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int t0;
    bit stayed;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(frame_n == 1 && irdy_n == 1, "R1 strobes idle", {frame_n, irdy_n}, 2'b11);
    chk(fifo_empty == 1 && aon_ready == 1, "R1 fifo flags", {fifo_empty, aon_ready}, 2'b11);
    chk(irq == 0, "R1 irq", irq, 0);

    // R11: data stored but zero count -> no transaction
    for (int i = 0; i < 3; i++) push_word(32'hA000_0000 + i);
    stayed = 1;
    repeat (10) begin @(negedge clk); if (!irdy_n) stayed = 0; end
    chk(stayed && !fifo_empty, "R11 no start at zero count", stayed, 1);

    // R2: fill to 8
    for (int i = 3; i < 8; i++) push_word(32'hA000_0000 + i);
    chk(aon_ready == 0, "R2 ready low at 8 words", aon_ready, 0);
    mode = 0;
    load_count(32);
    while (!irq) @(negedge clk);
    chk(fifo_empty == 1 && aon_ready == 1, "R2 empty after drain", {fifo_empty, aon_ready}, 2'b11);
    chk(exp_q.size() == 0 && acc_since == 8, "R3 all 8 words out", acc_since, 8);

    // R4 / R7: retry of a lone word
    push_word(32'hB000_0001);
    retry_budget = 1;
    mode = 3;
    load_count(4);
    while (!fifo_empty) @(negedge clk);
    idle(1);
    chk(irq == 0 && acc_since == 0, "R4 empty while word held, no irq", {irq, 8'(acc_since)}, 0);
    while (!irq) @(negedge clk);
    chk(acc_since == 1 && exp_q.size() == 0, "R7 retried word counted once", acc_since, 1);

    // R5 / R6: add-on write during last phase
    mode = 2;
    push_word(32'hC000_0001);
    t0 = txn;
    load_count(8);
    while (irdy_n) @(negedge clk);
    chk(frame_n == 1, "R5 single word phase is last", frame_n, 1);
    push_word(32'hC000_0002);
    idle(2);
    chk(frame_n == 1 && irdy_n == 0, "R6 late write does not extend", {frame_n, irdy_n}, 2'b10);
    mode = 0;
    while (!(irq && exp_q.size() == 0)) @(negedge clk);
    chk(txn - t0 == 2, "R6 late word in new transaction", txn - t0, 2);

    // R9: load 4 mid-burst
    mode = 2;
    for (int i = 0; i < 6; i++) push_word(32'hD000_0000 + i);
    load_count(24);
    while (irdy_n) @(negedge clk);
    idle(2);
    load_count(4);
    mode = 0;
    idle(20);
    chk(acc_since == 1, "R9 one phase after count 4", acc_since, 1);
    chk(irq == 1 && frame_n == 1 && irdy_n == 1 && !fifo_empty, "R9 bus released with data left",
        {irq, frame_n, irdy_n, fifo_empty}, 4'b1110);
    load_count(20);
    while (!(acc_since == 5 && irq)) @(negedge clk);
    chk(exp_q.size() == 0, "R9 rest drained after reload", exp_q.size(), 0);

    // R10: disconnect on every phase
    mode = 4;
    for (int i = 0; i < 3; i++) push_word(32'hE000_0000 + i);
    t0 = txn;
    load_count(12);
    while (!irq) @(negedge clk);
    chk(txn - t0 == 3, "R10 one word per disconnect transaction", txn - t0, 3);
    chk(exp_q.size() == 0, "R10 all words sent", exp_q.size(), 0);

    // R8: irq masked
    irq_en = 1'b0;
    mode = 0;
    push_word(32'hF000_0001);
    load_count(4);
    while (acc_since < 1) @(negedge clk);
    idle(3);
    chk(irq == 0, "R8 irq masked", irq, 0);
    irq_en = 1'b1;
    #0;
    chk(irq == 1, "R8 irq unmasked", irq, 1);

    // R3 random stress: retries, waits, disconnects
    mode = 1;
    load_count(400);
    for (int i = 0; i < 100; i++) begin
      push_word(32'h1000_0000 + i * 7);
      idle($urandom % 3);
    end
    while (!(irq && exp_q.size() == 0)) @(negedge clk);
    chk(acc_since == 100, "R3 random no loss or duplicate", acc_since, 100);
    idle(10);
    chk(frame_n == 1 && irdy_n == 1, "R11 idle after count exhausted", {frame_n, irdy_n}, 2'b11);
    finish_run();
  end
endmodule